// File: doc/BRIEF.md
# Banked Word Memory Built from Narrow Chips

This block is an 8-word by 4-bit synchronous memory built from four identical 4-word by 2-bit chip models. Each chip holds one flip-flop per stored bit. A row decoder inside the chip turns the 2-bit chip address into a single word line. A chip enable gates both the capture of write data and the drive of the chip's outputs.

The chips are arranged as two pairs. Within a pair, one chip holds data bits 1:0 and the other holds bits 3:2, so one pair together supplies a full 4-bit word. One system address bit chooses the pair. By default this is the top bit, so words 0 to 3 sit in the first pair and words 4 to 7 in the second. A parameter can instead place consecutive words in alternating pairs by using the bottom address bit.

A single master drives the address, the write data, a write request and a read request. A write takes effect on the rising clock edge. A read returns the stored word without latency. When no read is requested, the read data is 0 and never floats.

Top module: `banked_mem`

## Requirements
- R1: A synchronous active-low reset clears every stored word to 0, so each of the eight addresses then reads 0.
- R2: With `wr_req` high at a rising edge, `wr_data` is stored at `addr`. From the next cycle, a read with `rd_req` high and `wr_req` low returns it on `rd_data` in the same cycle as the address, with no register stage.
- R3: With the default high-order bank mapping, `addr[2]` selects the chip pair, with 0 for words 0 to 3 and 1 for words 4 to 7. `addr[1:0]` is the chip address. All eight addresses hold separate data.
- R4: Bits 1:0 of each word live in one chip of the pair and bits 3:2 in the other. Each half is stored and returned intact. For example, writing 4'h5 to address 3 stores 2'b01 in both chips at chip address 3, and reads back 4'h5.
- R5: While `rd_req` is low, `rd_data` is 0.
- R6: While `wr_req` is low, no stored word changes, whatever `wr_data` and `addr` carry.
- R7: A write changes only the addressed word. The other seven words keep their values.
- R8: While its enable is high, each chip's row decoder raises exactly one word line, the one numbered by the chip address. While the enable is low, it raises none. Each chip row therefore holds separate data.
- R9: A chip whose select is low captures nothing on a write, and its data outputs read 0.
- R10: With the low-order bank mapping, `addr[0]` selects the pair and `addr[2:1]` is the chip address. The port behaviour of R1 to R7 is unchanged.
- R11: `wr_req` and `rd_req` high together act as a write. `rd_data` in that cycle is not defined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 3 | System word address |
| wr_data | input | 4 | Data to store |
| wr_req | input | 1 | Write request |
| rd_req | input | 1 | Read request; low forces `rd_data` to 0 |
| rd_data | output | 4 | Word read from the addressed location |

## Verification
The assertions check on every cycle that a selected chip captures its input at the addressed row and that a deselected or idle chip keeps all of its cells. They also check that the decoder raises one line only while enabled, that exactly one pair is selected, and that `rd_data` stays 0 without a read request. Only the bench scenarios can show that the address map keeps the eight words apart and that the two halves of a word recombine correctly. The same holds for the reset contents, the stated write of 5 to address 3, the combined write-and-read case, and the low-order mapping, which is run on a second instance.

// File: rtl/banked_mem_pkg.sv
// Package: shared types for the banked word memory.
// Assumes: nothing beyond IEEE 1800-2017.
package banked_mem_pkg;

    // Which system address bits choose the chip pair.
    typedef enum logic {
        BANK_HIGH = 1'b0,   // top address bits pick the pair
        BANK_LOW  = 1'b1    // bottom address bits pick the pair
    } bank_map_e;

endpackage

// File: rtl/row_decoder.sv
// Module: row_decoder
// Turns a binary row number into word lines. At most one line is high,
// and none is high while the enable is low.
// Assumes: SEL_W small enough that 2**SEL_W lines are practical.
module row_decoder #(
    parameter int SEL_W = 2
) (
    input  logic                   en,
    input  logic [SEL_W-1:0]       sel,
    output logic [(1<<SEL_W)-1:0]  lines
);

    localparam int LINES = 1 << SEL_W;

    // Purpose: raise the single line that matches sel while enabled.
    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            lines[i] = en && (sel == SEL_W'(i));
        end
    end

    // R8: exactly one line while enabled, none while disabled.
    always_comb begin
        if (en) begin
            p_one_line_r8: assert ($countones(lines) == 1 && lines[sel]);
        end else begin
            p_no_line_r8: assert ($countones(lines) == 0);
        end
    end

endmodule

// File: rtl/bank_map.sv
// Module: bank_map
// Splits a system address into a one-hot pair select and a chip address,
// using either high-order or low-order pair mapping.
// Assumes: PAIRS is a power of two and at least 2.
module bank_map
    import banked_mem_pkg::*;
#(
    parameter int        CHIP_AW = 2,
    parameter int        PAIRS   = 2,
    parameter bank_map_e MAP     = BANK_HIGH
) (
    input  logic [CHIP_AW+$clog2(PAIRS)-1:0] sys_addr,
    output logic [CHIP_AW-1:0]               chip_addr,
    output logic [PAIRS-1:0]                 pair_sel
);

    localparam int PB = $clog2(PAIRS);
    localparam int AW = CHIP_AW + PB;

    logic [PB-1:0] pair_idx;

    // Purpose: pick which address bits form the pair number and the row.
    generate
        if (MAP == BANK_HIGH) begin : g_high
            assign pair_idx  = sys_addr[AW-1 -: PB];
            assign chip_addr = sys_addr[CHIP_AW-1:0];
        end else begin : g_low
            assign pair_idx  = sys_addr[PB-1:0];
            assign chip_addr = sys_addr[AW-1:PB];
        end
    endgenerate

    // Purpose: expand the pair number to one select per pair.
    always_comb begin
        for (int p = 0; p < PAIRS; p++) begin
            pair_sel[p] = (pair_idx == PB'(p));
        end
    end

    // R3: one pair, and only one, is addressed at any time.
    always_comb begin
        p_one_pair_r3: assert ($countones(pair_sel) == 1);
    end

endmodule

// File: rtl/sram_chip.sv
// Module: sram_chip
// Narrow storage chip: 2**AW rows of DW flip-flops. A row captures din on a
// clock edge when the chip is selected, write is requested and the row's
// word line is up. dout shows the selected row on a read, otherwise 0.
// Assumes: single clock; synchronous active-low reset clears every cell.
module sram_chip #(
    parameter int AW = 2,
    parameter int DW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic          we,
    input  logic          oe,
    input  logic          cs,
    output logic [DW-1:0] dout
);

    localparam int ROWS = 1 << AW;

    logic [ROWS-1:0]          wline;
    logic [ROWS-1:0][DW-1:0]  cells;
    logic [DW-1:0]            row_bus;

    row_decoder #(.SEL_W(AW)) u_dec (
        .en    (cs),
        .sel   (addr),
        .lines (wline)
    );

    // One row of storage per word line.
    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            logic [DW-1:0] row_q;

            // Purpose: capture din when this row is strobed for writing.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    row_q <= '0;
                end else if (wline[r] && we) begin
                    row_q <= din;
                end
            end

            assign cells[r] = row_q;
        end
    endgenerate

    // Purpose: gather the row whose word line is up onto the internal bus.
    always_comb begin
        row_bus = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (wline[r]) begin
                row_bus = row_bus | cells[r];
            end
        end
    end

    // Purpose: drive the pins only on a read; 0 stands in for high impedance.
    assign dout = (oe && !we) ? row_bus : '0;

    // R2: a selected write lands in the addressed row on the next edge.
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we) |=> (cells[$past(addr)] == $past(din)));

    // R9: an unselected chip keeps every cell.
    p_hold_unsel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> $stable(cells));

    // R6: no write request, no cell changes.
    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cells));

endmodule

// File: rtl/banked_mem.sv
// Module: banked_mem
// Word memory built from PAIRS x SLICES narrow chips. Each pair holds one
// full word split across SLICES chips. The pair is chosen by high or low
// address bits, set by MAP. Reads are combinational from registered cells.
// Assumes: WORD_W is a multiple of CHIP_DW; PAIRS is a power of two >= 2.
module banked_mem
    import banked_mem_pkg::*;
#(
    parameter int        CHIP_AW = 2,
    parameter int        CHIP_DW = 2,
    parameter int        WORD_W  = 4,
    parameter int        PAIRS   = 2,
    parameter bank_map_e MAP     = BANK_HIGH
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [CHIP_AW+$clog2(PAIRS)-1:0] addr,
    input  logic [WORD_W-1:0]                wr_data,
    input  logic                             wr_req,
    input  logic                             rd_req,
    output logic [WORD_W-1:0]                rd_data
);

    localparam int SLICES = WORD_W / CHIP_DW;

    logic [CHIP_AW-1:0]                       chip_addr;
    logic [PAIRS-1:0]                         pair_sel;
    logic [PAIRS-1:0][SLICES-1:0][CHIP_DW-1:0] chip_q;

    bank_map #(
        .CHIP_AW (CHIP_AW),
        .PAIRS   (PAIRS),
        .MAP     (MAP)
    ) u_map (
        .sys_addr  (addr),
        .chip_addr (chip_addr),
        .pair_sel  (pair_sel)
    );

    // One chip for each slice of the word in each pair.
    generate
        for (genvar p = 0; p < PAIRS; p++) begin : g_pair
            for (genvar s = 0; s < SLICES; s++) begin : g_slice
                sram_chip #(
                    .AW (CHIP_AW),
                    .DW (CHIP_DW)
                ) u_chip (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .addr  (chip_addr),
                    .din   (wr_data[s*CHIP_DW +: CHIP_DW]),
                    .we    (wr_req),
                    .oe    (rd_req),
                    .cs    (pair_sel[p]),
                    .dout  (chip_q[p][s])
                );
            end
        end
    endgenerate

    // Purpose: merge the pair outputs; unselected chips contribute 0.
    always_comb begin
        rd_data = '0;
        for (int p = 0; p < PAIRS; p++) begin
            for (int s = 0; s < SLICES; s++) begin
                rd_data[s*CHIP_DW +: CHIP_DW] =
                    rd_data[s*CHIP_DW +: CHIP_DW] | chip_q[p][s];
            end
        end
    end

    // R5: without a read request the data lines sit at 0.
    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |-> (rd_data == '0));

endmodule

// File: tb/sim_banked_mem.sv
// Bench: directed scenarios for banked_mem in both mappings and for one chip.
module sim_banked_mem;
    import banked_mem_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic [3:0] wr_data = '0;
    logic       wr_req = 1'b0;
    logic       rd_req = 1'b0;
    logic [3:0] rd_hi, rd_lo;

    logic [1:0] c_addr = '0;
    logic [1:0] c_din = '0;
    logic       c_we = 1'b0, c_oe = 1'b0, c_cs = 1'b0;
    logic [1:0] c_dout;

    logic [3:0] model [8];
    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    banked_mem #(.MAP(BANK_HIGH)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .wr_req(wr_req), .rd_req(rd_req), .rd_data(rd_hi)
    );

    banked_mem #(.MAP(BANK_LOW)) u1 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .wr_req(wr_req), .rd_req(rd_req), .rd_data(rd_lo)
    );

    sram_chip #(.AW(2), .DW(2)) u_chip (
        .clk(clk), .rst_n(rst_n), .addr(c_addr), .din(c_din),
        .we(c_we), .oe(c_oe), .cs(c_cs), .dout(c_dout)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) model[i] = '0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] d, input logic also_rd);
        @(negedge clk);
        addr = a; wr_data = d; wr_req = 1'b1; rd_req = also_rd;
        @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0;
        model[a] = d;
    endtask

    // Read both instances and compare with the model.
    task automatic rd_check(input string req, input logic [2:0] a);
        @(negedge clk);
        addr = a; rd_req = 1'b1; wr_req = 1'b0;
        #1;
        check({req, " high map"}, rd_hi, model[a]);
        check({req, " low map R10"}, rd_lo, model[a]);
        rd_req = 1'b0;
    endtask

    task automatic t_reset_state();
        for (int i = 0; i < 8; i++) rd_check("R1 reset clears", 3'(i));
    endtask

    task automatic t_stated_write();
        wr(3'd3, 4'h5, 1'b0);
        rd_check("R2 R4 write 5 at 3", 3'd3);
        @(negedge clk); addr = 3'd3; rd_req = 1'b1; #1;
        check("R4 low half 01", {2'b00, rd_hi[1:0]}, 4'h1);
        check("R4 high half 01", {2'b00, rd_hi[3:2]}, 4'h1);
        rd_req = 1'b0;
    endtask

    task automatic t_fill_all();
        for (int i = 0; i < 8; i++) wr(3'(i), 4'((i * 5 + 9) & 15), 1'b0);
        for (int i = 0; i < 8; i++) rd_check("R3 R7 distinct words", 3'(i));
    endtask

    task automatic t_single_change();
        wr(3'd6, 4'hC, 1'b0);
        for (int i = 0; i < 8; i++) rd_check("R7 only addressed word", 3'(i));
        @(negedge clk); addr = 3'd6; rd_req = 1'b1; #1;
        check("R4 split of C", {rd_hi[3:2], rd_hi[1:0]}, 4'hC);
        rd_req = 1'b0;
    endtask

    task automatic t_no_read();
        @(negedge clk); addr = 3'd6; rd_req = 1'b0; #1;
        check("R5 no read high map", rd_hi, 4'h0);
        check("R5 no read low map", rd_lo, 4'h0);
    endtask

    task automatic t_no_write();
        @(negedge clk);
        addr = 3'd2; wr_data = ~model[2]; wr_req = 1'b0;
        @(negedge clk);
        addr = 3'd5; wr_data = ~model[5];
        @(negedge clk);
        rd_check("R6 ignored data", 3'd2);
        rd_check("R6 ignored data", 3'd5);
    endtask

    task automatic t_write_and_read();
        wr(3'd1, 4'hA, 1'b1);
        rd_check("R11 both requests write", 3'd1);
    endtask

    task automatic t_chip();
        // R8: each row of a selected chip is separate.
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            c_cs = 1'b1; c_we = 1'b1; c_oe = 1'b0; c_addr = 2'(r); c_din = 2'(3 - r);
        end
        @(negedge clk); c_we = 1'b0;
        for (int r = 0; r < 4; r++) begin
            @(negedge clk); c_addr = 2'(r); c_oe = 1'b1; #1;
            check("R8 chip row", {2'b00, c_dout}, 4'(3 - r));
        end
        // R9: deselected chip neither captures nor drives.
        @(negedge clk);
        c_cs = 1'b0; c_we = 1'b1; c_oe = 1'b0; c_addr = 2'd0; c_din = 2'd0;
        @(negedge clk); c_we = 1'b0; c_oe = 1'b1; #1;
        check("R9 unselected output 0", {2'b00, c_dout}, 4'h0);
        @(negedge clk); c_cs = 1'b1; #1;
        check("R9 unselected no write", {2'b00, c_dout}, 4'h3);
        c_oe = 1'b0; c_cs = 1'b0;
    endtask

    task automatic t_reset_again();
        do_reset();
        rd_check("R1 reset after writes", 3'd6);
        rd_check("R1 reset after writes", 3'd1);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        t_reset_state();
        t_stated_write();
        t_fill_all();
        t_single_change();
        t_no_read();
        t_no_write();
        t_write_and_read();
        t_chip();
        t_reset_again();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule